// File: doc/BRIEF.md
# Halfword Instruction Aligner

This block sits between a word-wide instruction fetch stage and the decoder of a machine whose instructions are either one or two halfwords long. Each accepted fetch word is aligned on a four-byte boundary. The aligner walks through it one halfword at a time. It tells each instruction's length from the top five bits of its first halfword, and hands the decoder one complete instruction per handshake, together with the instruction's byte address and the PC value that instruction reads.

A two-halfword instruction may begin in the upper half of a fetch word. Its second half then arrives with the next word. In that case the aligner parks the first halfword and joins it to the lower half of the following word before it offers the instruction. When the fetch stage is redirected, the aligner discards everything it holds. If the new target lies in the upper half of a word, the lower halfword of the first word fetched afterwards is skipped. Both sides use a valid/ready handshake. Fetch words are accepted only while the aligner has room for them.

Top module: `hw_aligner`

## Requirements
- R1: A first halfword whose bits [15:11] equal 5'b11101, 5'b11110 or 5'b11111 starts a 32-bit instruction, and `dec_wide` is 1 for it. Every other first halfword is a whole 16-bit instruction, and `dec_wide` is 0 for it.
- R2: A 16-bit instruction is offered with the halfword in `dec_instr[15:0]` and zeros in `dec_instr[31:16]`. The next instruction's address is 2 higher.
- R3: A 32-bit instruction that fits inside one fetch word is offered with its first halfword in `dec_instr[15:0]` and its second halfword in `dec_instr[31:16]`. The next instruction's address is 4 higher.
- R4: A 32-bit instruction that starts in the upper half of a fetch word is offered only after the next fetch word has arrived. It is offered in the same layout as R3: the parked first halfword below, the lower half of the new word above.
- R5: `dec_pc` equals `dec_addr` plus 4 for both lengths.
- R6: While `redirect_valid` is high, `fetch_ready` and `dec_valid` are low. In the cycle after a redirect, `dec_valid` is low. Any parked halfword is discarded. The first instruction offered afterwards is the one at the target address. When `redirect_odd_hw` is 1, that address is the upper half of the first fetched word.
- R7: While `dec_valid` is high and `dec_ready` is low, the offered instruction and address stay unchanged in the next cycle, unless a redirect arrives. No instruction is lost or repeated.
- R8: Bit 0 of `dec_addr` is always zero.
- R9: After reset, `dec_valid` is low. Once the internal reset has been released, `fetch_ready` is high.
- R10: For the stream 0x4000 (16-bit), 0x4002 (32-bit), 0x4006 (16-bit), 0x4008 (16-bit), 0x400A (32-bit), exactly those five instructions come out, in that order and with those addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| fetch_valid | input | 1 | A fetch word is present |
| fetch_ready | output | 1 | The aligner takes the fetch word this cycle |
| fetch_word | input | 32 | Fetch word; the lower address is in bits [15:0] |
| fetch_addr | input | ADDR_W | Byte address of the fetch word, aligned to four bytes |
| redirect_valid | input | 1 | Flush everything held; fetch restarts at a new target |
| redirect_odd_hw | input | 1 | The redirect target is the upper halfword of its word |
| dec_valid | output | 1 | An instruction is offered |
| dec_ready | input | 1 | The decoder takes the offered instruction |
| dec_instr | output | 32 | Instruction; first halfword in bits [15:0] |
| dec_wide | output | 1 | 0 = 16-bit instruction, 1 = 32-bit instruction |
| dec_addr | output | ADDR_W | Byte address of the instruction |
| dec_pc | output | ADDR_W | PC value the instruction reads (address plus 4) |

## Verification
A fixed five-instruction program checks the exact order and addresses against the expected list. A long mixed image, run with both sides always ready, separates the three length cases: narrow, wide inside one word, and wide across a word boundary. Recurring gap and stall patterns on fetch and decode show whether an instruction is dropped, duplicated or changes while it waits. Redirects to the upper halfword, including one onto a wide instruction and one issued while a halfword is parked, show the skip and the flush working.

// File: rtl/hw_aligner_pkg.sv
`timescale 1ns/1ps
package hw_aligner_pkg;
  localparam int HW_W   = 16;
  localparam int WORD_W = 2 * HW_W;

  // Which action the aligner takes on the halfword under the cursor
  typedef enum logic [2:0] {
    PICK_NONE,    // nothing usable
    PICK_JOIN,    // parked halfword + lower half of the word
    PICK_NARROW,  // one 16-bit instruction
    PICK_FULL,    // whole word is one 32-bit instruction
    PICK_PARK     // upper half starts a 32-bit instruction: keep it
  } pick_e;
endpackage

// File: rtl/hwa_len_detect.sv
`timescale 1ns/1ps
module hwa_len_detect
  import hw_aligner_pkg::*;
(
  input  logic [HW_W-1:0] first_hw,
  output logic            is_wide
);
  // Top three bits all ones and the next two not both zero
  always_comb begin
    is_wide = (first_hw[HW_W-1 -: 3] == 3'b111) && (first_hw[HW_W-4 -: 2] != 2'b00);
  end
endmodule

// File: rtl/hwa_word_slot.sv
`timescale 1ns/1ps
module hwa_word_slot
  import hw_aligner_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              load_hi,
  input  logic              consume,
  input  logic              step_hi,
  output logic              slot_vld,
  output logic              slot_hi,
  output logic [WORD_W-1:0] slot_word,
  output logic [ADDR_W-1:0] slot_addr
);
  logic vld_d, hi_d;

  always_comb begin
    vld_d = slot_vld;
    hi_d  = slot_hi;
    if (flush) begin
      vld_d = 1'b0;
    end else if (load) begin
      vld_d = 1'b1;
      hi_d  = load_hi;
    end else if (consume) begin
      vld_d = 1'b0;
    end else if (step_hi) begin
      hi_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_vld <= 1'b0;
      slot_hi  <= 1'b0;
    end else begin
      slot_vld <= vld_d;
      slot_hi  <= hi_d;
    end
  end

  // Datapath without reset, written only when a word is taken
  always_ff @(posedge clk) begin
    if (load) begin
      slot_word <= load_word;
      slot_addr <= load_addr;
    end
  end
endmodule

// File: rtl/hwa_carry_slot.sv
`timescale 1ns/1ps
module hwa_carry_slot
  import hw_aligner_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              capture,
  input  logic [HW_W-1:0]   cap_hw,
  input  logic [ADDR_W-1:0] cap_addr,
  input  logic              release_hw,
  output logic              car_vld,
  output logic [HW_W-1:0]   car_hw,
  output logic [ADDR_W-1:0] car_addr
);
  logic vld_d;

  always_comb begin
    vld_d = car_vld;
    if (flush)           vld_d = 1'b0;
    else if (capture)    vld_d = 1'b1;
    else if (release_hw) vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) car_vld <= 1'b0;
    else        car_vld <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (capture) begin
      car_hw   <= cap_hw;
      car_addr <= cap_addr;
    end
  end
endmodule

// File: rtl/hw_aligner.sv
`timescale 1ns/1ps
module hw_aligner
  import hw_aligner_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_valid,
  output logic              fetch_ready,
  input  logic [31:0]       fetch_word,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              redirect_valid,
  input  logic              redirect_odd_hw,
  output logic              dec_valid,
  input  logic              dec_ready,
  output logic [31:0]       dec_instr,
  output logic              dec_wide,
  output logic [ADDR_W-1:0] dec_addr,
  output logic [ADDR_W-1:0] dec_pc
);
  localparam logic [ADDR_W-1:0] WORD_MASK = ~ADDR_W'(3);
  localparam logic [ADDR_W-1:0] HW_STEP   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] PC_AHEAD  = ADDR_W'(4);

  // Reset: asserted at once, released on a clock edge
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic              slot_vld, slot_hi;
  logic [WORD_W-1:0] slot_word;
  logic [ADDR_W-1:0] slot_addr, slot_base;
  logic              car_vld;
  logic [HW_W-1:0]   car_hw, cur_hw;
  logic [ADDR_W-1:0] car_addr;
  logic              cur_wide;
  pick_e             pick;
  logic              offer, fire, consume, step_hi, capture, release_hw, load;
  logic              skip_q, skip_d;

  assign slot_base = slot_addr & WORD_MASK;
  assign cur_hw    = slot_hi ? slot_word[WORD_W-1:HW_W] : slot_word[HW_W-1:0];

  hwa_len_detect u_len (
    .first_hw (cur_hw),
    .is_wide  (cur_wide)
  );

  // Choose the action for the current cursor position
  always_comb begin
    pick = PICK_NONE;
    if (slot_vld) begin
      if (car_vld)        pick = PICK_JOIN;
      else if (!cur_wide) pick = PICK_NARROW;
      else if (!slot_hi)  pick = PICK_FULL;
      else                pick = PICK_PARK;
    end
  end

  // Output formatting
  always_comb begin
    offer     = 1'b0;
    dec_instr = '0;
    dec_wide  = 1'b0;
    dec_addr  = slot_base;
    unique case (pick)
      PICK_JOIN: begin
        offer     = 1'b1;
        dec_instr = {slot_word[HW_W-1:0], car_hw};
        dec_wide  = 1'b1;
        dec_addr  = car_addr;
      end
      PICK_NARROW: begin
        offer     = 1'b1;
        dec_instr = {{HW_W{1'b0}}, cur_hw};
        dec_addr  = slot_hi ? (slot_base | HW_STEP) : slot_base;
      end
      PICK_FULL: begin
        offer     = 1'b1;
        dec_instr = slot_word;
        dec_wide  = 1'b1;
      end
      default: ;
    endcase
  end

  assign dec_valid = offer && !redirect_valid;
  assign dec_pc    = dec_addr + PC_AHEAD;
  assign fire      = dec_valid && dec_ready;

  // Word and halfword movement
  always_comb begin
    consume    = (pick == PICK_PARK) ||
                 (fire && ((pick == PICK_FULL) || ((pick == PICK_NARROW) && slot_hi)));
    step_hi    = fire && ((pick == PICK_JOIN) || ((pick == PICK_NARROW) && !slot_hi));
    capture    = (pick == PICK_PARK) && !redirect_valid;
    release_hw = fire && (pick == PICK_JOIN);
  end

  assign fetch_ready = rst_sync_q && !redirect_valid && (!slot_vld || consume);
  assign load        = fetch_valid && fetch_ready;

  // Pending skip of the lower halfword after a redirect
  always_comb begin
    skip_d = skip_q;
    if (redirect_valid) skip_d = redirect_odd_hw;
    else if (load)      skip_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) skip_q <= 1'b0;
    else             skip_q <= skip_d;
  end

  hwa_word_slot #(.ADDR_W(ADDR_W)) u_slot (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .flush     (redirect_valid),
    .load      (load),
    .load_word (fetch_word),
    .load_addr (fetch_addr),
    .load_hi   (skip_q),
    .consume   (consume),
    .step_hi   (step_hi),
    .slot_vld  (slot_vld),
    .slot_hi   (slot_hi),
    .slot_word (slot_word),
    .slot_addr (slot_addr)
  );

  hwa_carry_slot #(.ADDR_W(ADDR_W)) u_carry (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .flush      (redirect_valid),
    .capture    (capture),
    .cap_hw     (slot_word[WORD_W-1:HW_W]),
    .cap_addr   (slot_base | HW_STEP),
    .release_hw (release_hw),
    .car_vld    (car_vld),
    .car_hw     (car_hw),
    .car_addr   (car_addr)
  );
endmodule

// File: rtl/hw_aligner_chk.sv
`timescale 1ns/1ps
module hw_aligner_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fetch_ready,
  input logic              redirect_valid,
  input logic              dec_valid,
  input logic              dec_ready,
  input logic [31:0]       dec_instr,
  input logic              dec_wide,
  input logic [ADDR_W-1:0] dec_addr
);
  AST_WIDE_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> (dec_wide == (dec_instr[15:11] == 5'b11101 || dec_instr[15:11] == 5'b11110 ||
                                dec_instr[15:11] == 5'b11111))); // R1

  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_wide) |-> (dec_instr[31:16] == 16'h0)); // R2

  AST_REDIRECT_HOLDS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> (!fetch_ready && !dec_valid)); // R6

  AST_REDIRECT_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |=> !dec_valid); // R6

  AST_STALL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_ready && !redirect_valid) |=>
      (redirect_valid || (dec_valid && $stable(dec_instr) && $stable(dec_addr)))); // R7

  AST_ADDR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> (dec_addr[0] == 1'b0)); // R8
endmodule

bind hw_aligner hw_aligner_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .fetch_ready    (fetch_ready),
  .redirect_valid (redirect_valid),
  .dec_valid      (dec_valid),
  .dec_ready      (dec_ready),
  .dec_instr      (dec_instr),
  .dec_wide       (dec_wide),
  .dec_addr       (dec_addr)
);

// File: tb/hw_aligner_tb_top.sv
`timescale 1ns/1ps
module hw_aligner_tb_top;
  logic        clk;
  logic        rst_n;
  logic        fetch_valid, fetch_ready;
  logic [31:0] fetch_word, fetch_addr;
  logic        redirect_valid, redirect_odd_hw;
  logic        dec_valid, dec_ready, dec_wide;
  logic [31:0] dec_instr, dec_addr, dec_pc;

  hw_aligner #(.ADDR_W(32)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
    .fetch_word(fetch_word), .fetch_addr(fetch_addr),
    .redirect_valid(redirect_valid), .redirect_odd_hw(redirect_odd_hw),
    .dec_valid(dec_valid), .dec_ready(dec_ready), .dec_instr(dec_instr),
    .dec_wide(dec_wide), .dec_addr(dec_addr), .dec_pc(dec_pc)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int          checks = 0;
  int          errors = 0;
  logic [15:0] img [256];
  logic [31:0] model_addr, fetch_ptr, redir_target;
  logic [31:0] prev_instr, prev_addr;
  bit          stall_prev, after_redir, want_first, logging;
  int          log_n;
  logic [31:0] log_addr [8];
  bit          log_wide [8];

  function automatic logic [15:0] hw_at(logic [31:0] a);
    return img[a[8:1]];
  endfunction

  function automatic bit wide_start(logic [15:0] h);
    return (h[15:11] == 5'b11101) || (h[15:11] == 5'b11110) || (h[15:11] == 5'b11111);
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Compare one accepted instruction with the walk through the image
  task automatic compare_fire();
    logic [15:0] lo;
    logic [31:0] exp_instr;
    bit          w;
    string       tag;
    lo = hw_at(model_addr);
    w  = wide_start(lo);
    exp_instr = w ? {hw_at(model_addr + 2), lo} : {16'h0, lo};
    tag = w ? (model_addr[1] ? "R4" : "R3") : "R2";
    check(dec_addr == model_addr, tag, "address", dec_addr, model_addr);
    check(dec_instr == exp_instr, tag, "instruction", dec_instr, exp_instr);
    check(dec_wide == w, "R1", "length flag", 32'(dec_wide), 32'(w));
    check(dec_pc == dec_addr + 4, "R5", "pc", dec_pc, dec_addr + 4);
    check(dec_addr[0] == 1'b0, "R8", "address bit0", dec_addr, dec_addr & ~32'h1);
    if (want_first) begin
      check(dec_addr == redir_target, "R6", "first after redirect", dec_addr, redir_target);
      want_first = 0;
    end
    if (logging && log_n < 8) begin
      log_addr[log_n] = dec_addr;
      log_wide[log_n] = dec_wide;
      log_n++;
    end
    model_addr = model_addr + (w ? 32'd4 : 32'd2);
  endtask

  task automatic cycle(bit fv, bit dr, bit rv, logic [31:0] ra);
    @(negedge clk);
    fetch_valid     = fv && !rv;
    fetch_addr      = fetch_ptr;
    fetch_word      = {hw_at(fetch_ptr + 2), hw_at(fetch_ptr)};
    dec_ready       = dr;
    redirect_valid  = rv;
    redirect_odd_hw = ra[1];
    #5;
    if (after_redir) check(!dec_valid, "R6", "valid after redirect", 32'(dec_valid), 0);
    if (stall_prev && !rv) begin
      check(dec_valid, "R7", "valid held", 32'(dec_valid), 1);
      check(dec_instr == prev_instr, "R7", "instr held", dec_instr, prev_instr);
      check(dec_addr == prev_addr, "R7", "addr held", dec_addr, prev_addr);
    end
    if (rv) begin
      check(!fetch_ready, "R6", "fetch_ready in redirect", 32'(fetch_ready), 0);
      check(!dec_valid, "R6", "dec_valid in redirect", 32'(dec_valid), 0);
      model_addr   = ra;
      redir_target = ra;
      fetch_ptr    = ra & ~32'h3;
      after_redir  = 1;
      want_first   = 1;
      stall_prev   = 0;
    end else begin
      after_redir = 0;
      if (fv && fetch_ready) fetch_ptr = fetch_ptr + 4;
      if (dec_valid && dec_ready) compare_fire();
      stall_prev = dec_valid && !dec_ready;
      prev_instr = dec_instr;
      prev_addr  = dec_addr;
    end
  endtask

  initial begin
    #(20ns * 100000);
    errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] ex_a [5];
    bit          ex_w [5];
    for (int i = 0; i < 256; i++) begin
      logic [15:0] v;
      v = 16'((i * 40503) ^ (i << 7) ^ 16'h2A5C);
      if ((i * 7) % 5 == 0) v[15:11] = 5'b11101 + 5'(i % 3);
      img[i] = v;
    end
    // Fixed program at 0x4000
    img[0] = 16'h4608; img[1] = 16'hF000; img[2] = 16'hB802; img[3] = 16'hBF00;
    img[4] = 16'hBF00; img[5] = 16'hE812; img[6] = 16'h3456; img[7] = 16'hBF00;
    // Wide instruction at an upper-halfword redirect target 0x4102
    img[129] = 16'hF123; img[130] = 16'h5555;
    // Narrow then straddling wide at 0x4140 / 0x4142
    img[160] = 16'h2001; img[161] = 16'hF7AA; img[162] = 16'h8000;

    fetch_valid = 0; fetch_word = 0; fetch_addr = 0; redirect_valid = 0;
    redirect_odd_hw = 0; dec_ready = 0;
    fetch_ptr = 32'h4000; model_addr = 32'h4000; redir_target = 0;
    stall_prev = 0; after_redir = 0; want_first = 0; logging = 0; log_n = 0;
    prev_instr = 0; prev_addr = 0;

    rst_n = 0;
    repeat (3) @(negedge clk);
    check(!dec_valid, "R9", "dec_valid in reset", 32'(dec_valid), 0);
    check(!fetch_ready, "R9", "fetch_ready in reset", 32'(fetch_ready), 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    #5;
    check(!dec_valid, "R9", "dec_valid after reset", 32'(dec_valid), 0);
    check(fetch_ready, "R9", "fetch_ready after reset", 32'(fetch_ready), 1);

    // R10: fixed program
    cycle(0, 1, 1, 32'h4000);
    logging = 1;
    repeat (12) cycle(1, 1, 0, 0);
    logging = 0;
    ex_a = '{32'h4000, 32'h4002, 32'h4006, 32'h4008, 32'h400A};
    ex_w = '{0, 1, 0, 0, 1};
    check(log_n >= 5, "R10", "instruction count", 32'(log_n), 5);
    for (int k = 0; k < 5; k++) begin
      check(log_addr[k] == ex_a[k], "R10", "order address", log_addr[k], ex_a[k]);
      check(log_wide[k] == ex_w[k], "R10", "order length", 32'(log_wide[k]), 32'(ex_w[k]));
    end

    // Mixed image at full rate
    cycle(0, 1, 1, 32'h4020);
    repeat (80) cycle(1, 1, 0, 0);

    // Gaps on fetch, stalls on decode
    for (int k = 0; k < 150; k++) cycle(k % 3 != 0, k % 4 != 1, 0, 0);
    for (int k = 0; k < 150; k++) cycle(k % 2 == 0, k % 5 < 2, 0, 0);

    // Redirect to upper halfwords
    cycle(1, 1, 1, 32'h4082);
    repeat (30) cycle(1, 1, 0, 0);
    cycle(1, 1, 1, 32'h4102);
    repeat (30) cycle(1, 0, 0, 0);
    repeat (30) cycle(1, 1, 0, 0);

    // Parked halfword discarded by a redirect
    cycle(0, 1, 1, 32'h4140);
    cycle(1, 0, 0, 0);
    cycle(0, 1, 0, 0);
    cycle(0, 1, 0, 0);
    cycle(0, 1, 0, 0);
    check(!dec_valid, "R4", "straddling waits for second word", 32'(dec_valid), 0);
    cycle(0, 1, 1, 32'h4180);
    repeat (40) cycle(1, 1, 0, 0);
    check(model_addr != 32'h4180, "R6", "progress after flush", model_addr, 32'h4180);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule